// File: doc/BRIEF.md
# Break and Interrupt Entry Sequencer

This block runs the entry sequence of a small 8-bit CPU core for its four ways into a handler. Three are hardware sources: maskable request, non-maskable request and reset. The fourth is the software break opcode `0x00`. All four use one five-step microsequence.

At each instruction boundary the core presents the opcode it has just fetched, that opcode's address, the status register and the stack pointer. If a hardware source is pending, the fetched opcode is discarded and a break is injected in its place. The sequence then pushes the return address and the status byte to the stack page, reads a two-byte vector, and reports the new PC, stack pointer and status.

The vector comes from an all-ones address by clearing low address bits. The status byte written to the stack carries a bit that tells a software break apart from a hardware entry. That bit is never kept in the status register.

Top module: `brk_entry_seq`

## Requirements
- R1: A sequence starts on the clock edge where `boundary_i` is high while idle, if a hardware source is pending or `opcode_i` is `0x00`. The next five cycles have `busy_o` high and access, in this order: `{0x01, sp}`, `{0x01, sp-1}`, `{0x01, sp-2}` (8-bit wrap), vector low byte, vector high byte. `done_o` is high in the cycle after.
- R2: The three stack cycles write, in order: PC high byte, PC low byte, then the status byte. The status byte has bit 5 forced to 1, bit 4 set to the origin bit, and the other bits taken from `status_i`.
- R3: With no hardware source pending, a fetched `0x00` pushes `pc_i + 2` (16-bit wrap), sets origin bit 4 to 1, and uses vector `0xFFFE`/`0xFFFF`.
- R4: A hardware entry ignores `opcode_i`, pushes `pc_i` unchanged, and sets origin bit 4 to 0.
- R5: Vector addresses are `0xFFFC`/`0xFFFD` for reset, `0xFFFA`/`0xFFFB` for non-maskable, and `0xFFFE`/`0xFFFF` for maskable.
- R6: When several sources are pending, the order is reset, then non-maskable, then maskable. A source that loses stays pending and is taken at a later boundary.
- R7: The maskable request (`irq_i`, level, active high, registered once) is ignored while `status_i` bit 2 is 1. A break opcode still starts a sequence in that case.
- R8: The non-maskable request is latched on a falling edge of `nmi_ni` and cleared when its sequence starts. A line held low does not trigger again.
- R9: A reset entry (from a high cycle on `reset_req_i`) keeps `we_o` low in all three stack cycles, but the stack pointer still steps down by 3.
- R10: In the `done_o` cycle:
  - `new_pc_o` = `{high vector byte, low vector byte}`;
  - `sp_o` = `sp_i - 3`;
  - `status_o` = `status_i` with bit 2 set and bit 4 unchanged.
- R11: A `boundary_i` pulse while the block is busy is ignored. A non-zero opcode with no source pending leaves the block idle.
- R12: After `rst_ni` is asserted low, `busy_o`, `we_o` and `done_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| boundary_i | input | 1 | Instruction boundary; opcode and context are valid |
| opcode_i | input | 8 | Fetched opcode |
| pc_i | input | 16 | Address of the fetched opcode |
| status_i | input | 8 | Status register |
| sp_i | input | 8 | Stack pointer |
| irq_i | input | 1 | Maskable request, level, active high |
| nmi_ni | input | 1 | Non-maskable request, falling edge |
| reset_req_i | input | 1 | Reset entry request |
| rdata_i | input | 8 | Read data for the vector fetch |
| addr_o | output | 16 | Bus address |
| wdata_o | output | 8 | Write data |
| we_o | output | 1 | Write strobe |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle completion pulse |
| new_pc_o | output | 16 | New PC loaded from the vector |
| sp_o | output | 8 | Stack pointer after the pushes |
| status_o | output | 8 | Status with interrupt-disable set |

## Verification
A wrongly selected source shows up at once, in the third stack cycle, as a wrong origin bit. It also shows up two cycles later as a vector address with the wrong bits cleared. A pending flag that is held too long or cleared too early appears at the next boundary: either an extra sequence starts, or an expected one does not.

A stack pointer that drifts shows up in the very next stack address. Any error in the return-address arithmetic shows in the first two writes. Every bus cycle of every sequence is compared against an expected stream, so a fault is reported within the cycle it occurs.

// File: rtl/bes_pkg.sv
package bes_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_PUSH_H, ST_PUSH_L, ST_PUSH_P, ST_VEC_L, ST_VEC_H, ST_DONE
  } state_e;

  typedef enum logic [1:0] {SRC_BRK, SRC_IRQ, SRC_NMI, SRC_RST} src_e;

  localparam int unsigned IFLAG_BIT  = 2;
  localparam int unsigned ORIGIN_BIT = 4;
  localparam int unsigned ONE_BIT    = 5;
endpackage

// File: rtl/bes_pending.sv
module bes_pending
  import bes_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic irq_i,
  input  logic nmi_ni,
  input  logic reset_req_i,
  input  logic irq_mask_i,
  input  logic take_i,
  input  src_e take_src_i,
  output logic hw_req_o,
  output src_e hw_src_o
);
  logic irq_q, nmi_prev_q, nmi_q, rst_q;
  logic nmi_fall;

  assign nmi_fall = nmi_prev_q & ~nmi_ni;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      irq_q      <= 1'b0;
      nmi_prev_q <= 1'b1;
      nmi_q      <= 1'b0;
      rst_q      <= 1'b0;
    end else begin
      irq_q      <= irq_i;
      nmi_prev_q <= nmi_ni;
      // a new edge wins over the clear
      if (nmi_fall)                               nmi_q <= 1'b1;
      else if (take_i && take_src_i == SRC_NMI)   nmi_q <= 1'b0;
      if (reset_req_i)                            rst_q <= 1'b1;
      else if (take_i && take_src_i == SRC_RST)   rst_q <= 1'b0;
    end
  end

  always_comb begin
    hw_req_o = 1'b1;
    if (rst_q)                     hw_src_o = SRC_RST;
    else if (nmi_q)                hw_src_o = SRC_NMI;
    else if (irq_q && !irq_mask_i) hw_src_o = SRC_IRQ;
    else begin
      hw_src_o = SRC_BRK;
      hw_req_o = 1'b0;
    end
  end
endmodule

// File: rtl/bes_vector.sv
module bes_vector
  import bes_pkg::*;
#(
  parameter int unsigned ADDR_W = 16
) (
  input  src_e              src_i,
  output logic [ADDR_W-1:0] vec_lo_o,
  output logic [ADDR_W-1:0] vec_hi_o
);
  localparam logic [ADDR_W-1:0] ALL_ONES = '1;

  logic [ADDR_W-1:0] base;

  always_comb begin
    base = ALL_ONES;
    if (src_i == SRC_RST) base[1] = 1'b0;
    if (src_i == SRC_NMI) base[2] = 1'b0;
  end

  assign vec_hi_o = base;
  assign vec_lo_o = {base[ADDR_W-1:1], 1'b0};
endmodule

// File: rtl/bes_fsm.sv
module bes_fsm
  import bes_pkg::*;
#(
  parameter int unsigned DATA_W     = 8,
  parameter logic [7:0]  BRK_OPCODE = 8'h00,
  parameter logic [7:0]  STACK_PAGE = 8'h01,
  localparam int unsigned ADDR_W    = 2 * DATA_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              boundary_i,
  input  logic [DATA_W-1:0] opcode_i,
  input  logic [ADDR_W-1:0] pc_i,
  input  logic [DATA_W-1:0] status_i,
  input  logic [DATA_W-1:0] sp_i,
  input  logic [DATA_W-1:0] rdata_i,
  input  logic              hw_req_i,
  input  src_e              hw_src_i,
  input  logic [ADDR_W-1:0] vec_lo_i,
  input  logic [ADDR_W-1:0] vec_hi_i,
  output logic              take_o,
  output src_e              src_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DATA_W-1:0] wdata_o,
  output logic              we_o,
  output logic              busy_o,
  output logic              done_o,
  output logic [ADDR_W-1:0] new_pc_o,
  output logic [DATA_W-1:0] sp_o,
  output logic [DATA_W-1:0] status_o
);
  state_e            state_q;
  src_e              src_q;
  logic [ADDR_W-1:0] pc_q;
  logic [DATA_W-1:0] status_q, sp_q, pushed_status;
  logic              start, push_we;

  assign start  = (state_q == ST_IDLE) && boundary_i &&
                  (hw_req_i || opcode_i == DATA_W'(BRK_OPCODE));
  assign take_o = start && hw_req_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      src_q    <= SRC_BRK;
      pc_q     <= '0;
      status_q <= '0;
      sp_q     <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (start) begin
          state_q  <= ST_PUSH_H;
          src_q    <= hw_req_i ? hw_src_i : SRC_BRK;
          // fetched break skips its padding byte
          pc_q     <= hw_req_i ? pc_i : pc_i + ADDR_W'(2);
          status_q <= status_i;
          sp_q     <= sp_i;
        end
        ST_PUSH_H: begin
          sp_q    <= sp_q - DATA_W'(1);
          state_q <= ST_PUSH_L;
        end
        ST_PUSH_L: begin
          sp_q    <= sp_q - DATA_W'(1);
          state_q <= ST_PUSH_P;
        end
        ST_PUSH_P: begin
          sp_q                <= sp_q - DATA_W'(1);
          status_q[IFLAG_BIT] <= 1'b1;
          state_q             <= ST_VEC_L;
        end
        ST_VEC_L: begin
          pc_q[DATA_W-1:0] <= rdata_i;
          state_q          <= ST_VEC_H;
        end
        ST_VEC_H: begin
          pc_q[ADDR_W-1:DATA_W] <= rdata_i;
          state_q               <= ST_DONE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    pushed_status             = status_q;
    pushed_status[ONE_BIT]    = 1'b1;
    pushed_status[ORIGIN_BIT] = (src_q == SRC_BRK);
  end

  assign push_we = (src_q != SRC_RST);

  always_comb begin
    addr_o  = '0;
    wdata_o = '0;
    we_o    = 1'b0;
    unique case (state_q)
      ST_PUSH_H: begin
        addr_o  = {STACK_PAGE, sp_q};
        wdata_o = pc_q[ADDR_W-1:DATA_W];
        we_o    = push_we;
      end
      ST_PUSH_L: begin
        addr_o  = {STACK_PAGE, sp_q};
        wdata_o = pc_q[DATA_W-1:0];
        we_o    = push_we;
      end
      ST_PUSH_P: begin
        addr_o  = {STACK_PAGE, sp_q};
        wdata_o = pushed_status;
        we_o    = push_we;
      end
      ST_VEC_L: addr_o = vec_lo_i;
      ST_VEC_H: addr_o = vec_hi_i;
      default: ;
    endcase
  end

  assign busy_o   = (state_q != ST_IDLE) && (state_q != ST_DONE);
  assign done_o   = (state_q == ST_DONE);
  assign new_pc_o = pc_q;
  assign sp_o     = sp_q;
  assign status_o = status_q;
  assign src_o    = src_q;
endmodule

// File: rtl/brk_entry_seq.sv
module brk_entry_seq
  import bes_pkg::*;
#(
  parameter int unsigned DATA_W     = 8,
  parameter logic [7:0]  BRK_OPCODE = 8'h00,
  parameter logic [7:0]  STACK_PAGE = 8'h01,
  localparam int unsigned ADDR_W    = 2 * DATA_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              boundary_i,
  input  logic [DATA_W-1:0] opcode_i,
  input  logic [ADDR_W-1:0] pc_i,
  input  logic [DATA_W-1:0] status_i,
  input  logic [DATA_W-1:0] sp_i,
  input  logic              irq_i,
  input  logic              nmi_ni,
  input  logic              reset_req_i,
  input  logic [DATA_W-1:0] rdata_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DATA_W-1:0] wdata_o,
  output logic              we_o,
  output logic              busy_o,
  output logic              done_o,
  output logic [ADDR_W-1:0] new_pc_o,
  output logic [DATA_W-1:0] sp_o,
  output logic [DATA_W-1:0] status_o
);
  logic              hw_req, take;
  src_e              hw_src, src;
  logic [ADDR_W-1:0] vec_lo, vec_hi;

  bes_pending u_pending (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .irq_i       (irq_i),
    .nmi_ni      (nmi_ni),
    .reset_req_i (reset_req_i),
    .irq_mask_i  (status_i[IFLAG_BIT]),
    .take_i      (take),
    .take_src_i  (hw_src),
    .hw_req_o    (hw_req),
    .hw_src_o    (hw_src)
  );

  bes_vector #(.ADDR_W(ADDR_W)) u_vector (
    .src_i    (src),
    .vec_lo_o (vec_lo),
    .vec_hi_o (vec_hi)
  );

  bes_fsm #(
    .DATA_W     (DATA_W),
    .BRK_OPCODE (BRK_OPCODE),
    .STACK_PAGE (STACK_PAGE)
  ) u_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .boundary_i (boundary_i),
    .opcode_i   (opcode_i),
    .pc_i       (pc_i),
    .status_i   (status_i),
    .sp_i       (sp_i),
    .rdata_i    (rdata_i),
    .hw_req_i   (hw_req),
    .hw_src_i   (hw_src),
    .vec_lo_i   (vec_lo),
    .vec_hi_i   (vec_hi),
    .take_o     (take),
    .src_o      (src),
    .addr_o     (addr_o),
    .wdata_o    (wdata_o),
    .we_o       (we_o),
    .busy_o     (busy_o),
    .done_o     (done_o),
    .new_pc_o   (new_pc_o),
    .sp_o       (sp_o),
    .status_o   (status_o)
  );
endmodule

// File: rtl/bes_checker.sv
module bes_checker #(
  parameter int unsigned DATA_W     = 8,
  parameter logic [7:0]  STACK_PAGE = 8'h01,
  localparam int unsigned ADDR_W    = 2 * DATA_W
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [ADDR_W-1:0] addr_o,
  input logic              we_o,
  input logic              busy_o,
  input logic              done_o,
  input logic [DATA_W-1:0] sp_o
);
  AST_WRITE_ON_STACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_o |-> (busy_o && addr_o[ADDR_W-1:DATA_W] == STACK_PAGE)); // R1

  AST_SP_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_o |=> (sp_o == $past(sp_o) - DATA_W'(1))); // R1

  AST_VEC_HIGH_PAGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !we_o && addr_o[ADDR_W-1:DATA_W] != STACK_PAGE)
      |-> (addr_o[ADDR_W-1:3] == '1)); // R5

  AST_DONE_AFTER_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> ($past(busy_o) && !busy_o)); // R10

  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R10
endmodule

bind brk_entry_seq bes_checker #(
  .DATA_W     (DATA_W),
  .STACK_PAGE (STACK_PAGE)
) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .addr_o (addr_o),
  .we_o   (we_o),
  .busy_o (busy_o),
  .done_o (done_o),
  .sp_o   (sp_o)
);

// File: tb/brk_entry_seq_bench.sv
module brk_entry_seq_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        boundary = 1'b0;
  logic [7:0]  opcode = 8'hEA;
  logic [15:0] pc = '0;
  logic [7:0]  status = '0;
  logic [7:0]  sp = '0;
  logic        irq = 1'b0;
  logic        nmi_n = 1'b1;
  logic        reset_req = 1'b0;
  logic [7:0]  rdata;
  logic [15:0] addr, new_pc;
  logic [7:0]  wdata, sp_out, status_out;
  logic        we, busy, done;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  string cur_req = "R1";

  typedef struct packed {
    logic        is_done;
    logic [15:0] addr;
    logic        we;
    logic [7:0]  data;
    logic [7:0]  sp;
    logic [7:0]  st;
  } item_t;

  item_t exp_q[$];

  always #5 clk = ~clk;

  function automatic logic [7:0] mem_rd(input logic [15:0] a);
    return (a[15:8] == 8'hFF) ? (a[7:0] ^ 8'h3C) : 8'h00;
  endfunction

  assign rdata = mem_rd(addr);

  brk_entry_seq u_brk_entry_seq (
    .clk_i(clk), .rst_ni(rst_n), .boundary_i(boundary), .opcode_i(opcode),
    .pc_i(pc), .status_i(status), .sp_i(sp), .irq_i(irq), .nmi_ni(nmi_n),
    .reset_req_i(reset_req), .rdata_i(rdata), .addr_o(addr), .wdata_o(wdata),
    .we_o(we), .busy_o(busy), .done_o(done), .new_pc_o(new_pc),
    .sp_o(sp_out), .status_o(status_out)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h (t=%0t)", req, act, exp, $time);
    end
  endtask

  // src: 0 break, 1 irq, 2 nmi, 3 reset
  task automatic expect_entry(input int src, input logic [15:0] ppc,
                              input logic [7:0] st, input logic [7:0] s);
    logic [15:0] vlo;
    logic        wr;
    logic [7:0]  pst;
    vlo = (src == 3) ? 16'hFFFC : (src == 2) ? 16'hFFFA : 16'hFFFE;
    wr  = (src != 3);
    pst = st;
    pst[5] = 1'b1;
    pst[4] = (src == 0);
    exp_q.push_back('{1'b0, {8'h01, s}, wr, ppc[15:8], 8'h00, 8'h00});
    exp_q.push_back('{1'b0, {8'h01, s - 8'd1}, wr, ppc[7:0], 8'h00, 8'h00});
    exp_q.push_back('{1'b0, {8'h01, s - 8'd2}, wr, pst, 8'h00, 8'h00});
    exp_q.push_back('{1'b0, vlo, 1'b0, 8'h00, 8'h00, 8'h00});
    exp_q.push_back('{1'b0, vlo + 16'd1, 1'b0, 8'h00, 8'h00, 8'h00});
    exp_q.push_back('{1'b1, {mem_rd(vlo + 16'd1), mem_rd(vlo)}, 1'b0, 8'h00,
                      s - 8'd3, st | 8'h04});
  endtask

  task automatic pulse(input logic [7:0] op, input logic [15:0] p,
                       input logic [7:0] st, input logic [7:0] s);
    @(negedge clk);
    opcode = op; pc = p; status = st; sp = s; boundary = 1'b1;
    @(negedge clk);
    boundary = 1'b0;
  endtask

  task automatic run(input int src, input logic [7:0] op, input logic [15:0] p,
                     input logic [7:0] st, input logic [7:0] s, input string req);
    cur_req = req;
    expect_entry(src, (src == 0) ? p + 16'd2 : p, st, s);
    pulse(op, p, st, s);
    while (exp_q.size() > 0) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic idle_after(input logic [7:0] op, input logic [15:0] p,
                            input logic [7:0] st, input string req);
    pulse(op, p, st, 8'h80);
    check(!busy && !we, req, {30'd0, busy, we}, 32'd0);
    @(negedge clk);
    check(!busy && !done, req, {30'd0, busy, done}, 32'd0);
  endtask

  task automatic wait_cycles(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && (busy || done)) begin
      if (exp_q.size() == 0) begin
        check(1'b0, {cur_req, " unexpected activity"}, {15'd0, busy, addr}, 32'd0);
      end else begin
        item_t it;
        it = exp_q.pop_front();
        if (it.is_done) begin
          check(done, "R10 done", {31'd0, done}, 32'd1);
          check(new_pc == it.addr, {cur_req, " R10 new_pc"}, {16'd0, new_pc}, {16'd0, it.addr});
          check(sp_out == it.sp, {cur_req, " R10 sp"}, {24'd0, sp_out}, {24'd0, it.sp});
          check(status_out == it.st, {cur_req, " R10 status"}, {24'd0, status_out}, {24'd0, it.st});
        end else begin
          check(busy && addr == it.addr, {cur_req, " R1 address"}, {15'd0, busy, addr},
                {15'd0, 1'b1, it.addr});
          check(we == it.we, {cur_req, " R9 strobe"}, {31'd0, we}, {31'd0, it.we});
          if (it.we)
            check(wdata == it.data, {cur_req, " R2 data"}, {24'd0, wdata}, {24'd0, it.data});
        end
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 50000) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R12 reset state
    check(!busy && !we && !done, "R12", {29'd0, busy, we, done}, 32'd0);
    rst_n = 1'b1;
    wait_cycles(2);
    check(!busy && !we && !done, "R12", {29'd0, busy, we, done}, 32'd0);

    // R3 fetched break
    run(0, 8'h00, 16'h1234, 8'h20, 8'hFD, "R3");
    // R3 PC wrap, status bit 4 stays clear in register
    run(0, 8'h00, 16'hFFFF, 8'hC3, 8'h10, "R3");
    // R11 ordinary opcode
    idle_after(8'hEA, 16'h0300, 8'h00, "R11");

    // R4 / R5 maskable
    irq = 1'b1;
    wait_cycles(2);
    run(1, 8'hA9, 16'h4000, 8'h00, 8'h80, "R4");
    // R7 masked
    idle_after(8'hEA, 16'h4002, 8'h04, "R7");
    run(0, 8'h00, 16'h4100, 8'h04, 8'h70, "R7");
    irq = 1'b0;
    wait_cycles(2);

    // R8 non-maskable, fetched break opcode is discarded (R4), sp wraps
    nmi_n = 1'b0;
    wait_cycles(2);
    run(2, 8'h00, 16'h2000, 8'h04, 8'h00, "R8");
    idle_after(8'hEA, 16'h2001, 8'h00, "R8");
    nmi_n = 1'b1;
    wait_cycles(2);

    // R9 reset entry
    @(negedge clk); reset_req = 1'b1;
    @(negedge clk); reset_req = 1'b0;
    run(3, 8'hEA, 16'h1111, 8'h81, 8'h40, "R9");

    // R6 priority
    @(negedge clk); reset_req = 1'b1; nmi_n = 1'b0; irq = 1'b1;
    @(negedge clk); reset_req = 1'b0;
    wait_cycles(2);
    run(3, 8'hEA, 16'h5000, 8'h00, 8'hFF, "R6");
    run(2, 8'hEA, 16'h6000, 8'h00, 8'hF0, "R6");
    run(1, 8'hEA, 16'h7000, 8'h00, 8'hE0, "R6");
    irq = 1'b0; nmi_n = 1'b1;
    wait_cycles(2);
    idle_after(8'hEA, 16'h7100, 8'h00, "R6");

    // R11 boundary while busy
    cur_req = "R11";
    expect_entry(0, 16'h3002, 8'h01, 8'hC0);
    pulse(8'h00, 16'h3000, 8'h01, 8'hC0);
    @(negedge clk);
    opcode = 8'h00; pc = 16'h3800; boundary = 1'b1;
    @(negedge clk);
    boundary = 1'b0;
    while (exp_q.size() > 0) @(negedge clk);
    @(negedge clk);
    check(!busy && !done, "R11 no second entry", {30'd0, busy, done}, 32'd0);

    check(exp_q.size() == 0, "R1 queue drained", exp_q.size(), 32'd0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule